// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This core runs one instruction per clock from a small fixed subset of a 32-bit load/store instruction set. Each cycle it presents the program counter on the instruction port and decodes the returned word. The word is one of three formats: register-register, register-immediate, or jump. The core executes it and writes the result into a 32-entry register file. On the same edge it moves to the next, branch or jump address. It has no pipeline and no delay slot, and it raises no traps.

Both memories are external and read combinationally. The instruction port supplies the word for the current PC in the same cycle. The data port has one address for loads and stores, a write-enable that is high only during a store, and combinational read data for loads. A debug select input reads any architectural register without disturbing execution. Reset is synchronous and active high.

Top module: `mini32_core`

## Requirements
- R1: While `rst` is high at a clock edge, the PC becomes 0 and all 32 registers become zero. In the first cycle after reset the instruction address is 0.
- R2: With opcode 000000, funct 100000 (add) and 100001 (addu) both write rs+rt to rd, and funct 100010 (sub) writes rs-rt to rd. All three wrap modulo 2^32 and none traps.
- R3: With opcode 000000, funct 100100 writes rs AND rt to rd, 100101 writes rs OR rt, and 100111 writes NOT(rs OR rt).
- R4: With opcode 000000, funct 000000 shifts rt left and funct 000010 shifts rt right. The shift amount is the shamt field, bits 10:6. Vacated bits fill with zeros, and the result goes to rd.
- R5: Register 0 always reads as zero, and any instruction that targets it leaves it unchanged.
- R6: Opcodes 001000 and 001001 write rs plus the sign-extended imm[15:0] to rt. Opcode 001100 writes rs AND the zero-extended immediate, and 001110 writes rs XOR the zero-extended immediate. Opcode 001111 writes {imm, 16'h0000} to rt.
- R7: For opcodes 100011 (load) and 101011 (store), the data address is rs plus the sign-extended imm. A load writes the read word to rt. A store drives rt as write data and raises the write-enable for exactly that cycle. Memories ignore address bits 1:0.
- R8: Opcode 000100 branches when rs equals rt, and opcode 000101 branches when they differ. The target is PC+4 plus the sign-extended imm shifted left by two. Otherwise the next PC is PC+4.
- R9: Opcodes 000010 and 000011 jump to {PC+4 bits 31:28, instr[25:0], 2'b00}. Opcode 000011 also writes PC+4 into register 31.
- R10: Any other opcode, and any other funct under opcode 000000, changes no register and no memory, and advances the PC by 4.
- R11: `dbg_data` shows the register chosen by `dbg_sel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Data byte address, rs + sign-extended offset |
| dmem_wdata | output | 32 | Store data (rt) |
| dmem_we | output | 1 | Store strobe, written at the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, combinational |
| dbg_sel | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Value of register `dbg_sel` |

## Verification
The checker assumes that the instruction word is valid and settled in the same cycle as the address that selects it. The PC-update properties compare the next address against the word that was on `imem_rdata`, so they hold only if instruction memory is a combinational function of `imem_addr`. The bench guarantees this with an asynchronous-read array indexed by address bits 7:2. The array holds only known words, and unused locations are zero, which decode as a harmless shift into register 0. Data memory is modelled the same way: reads are combinational and writes happen at the edge. Every program stays inside the 64-word windows of both arrays.

// File: rtl/mini32_core.sv
module mini32_core #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata,
  input  logic [RAW-1:0]  dbg_sel,
  output logic [XLEN-1:0] dbg_data
);
  localparam logic [5:0] OP_REG = 6'b000000, OP_J = 6'b000010, OP_JAL = 6'b000011,
                         OP_BEQ = 6'b000100, OP_BNE = 6'b000101, OP_ADDI = 6'b001000,
                         OP_ADDIU = 6'b001001, OP_ANDI = 6'b001100, OP_XORI = 6'b001110,
                         OP_LUI = 6'b001111, OP_LW = 6'b100011, OP_SW = 6'b101011;
  localparam logic [5:0] FN_SLL = 6'b000000, FN_SRL = 6'b000010, FN_ADD = 6'b100000,
                         FN_ADDU = 6'b100001, FN_SUB = 6'b100010, FN_AND = 6'b100100,
                         FN_OR = 6'b100101, FN_NOR = 6'b100111;
  localparam logic [RAW-1:0] LINK = RAW'(NREG - 1);

  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] regs [NREG];

  wire [5:0]     op  = imem_rdata[31:26];
  wire [5:0]     fn  = imem_rdata[5:0];
  wire [RAW-1:0] rs  = imem_rdata[25:21];
  wire [RAW-1:0] rt  = imem_rdata[20:16];
  wire [RAW-1:0] rd  = imem_rdata[15:11];
  wire [4:0]     sh  = imem_rdata[10:6];
  wire [15:0]    imm = imem_rdata[15:0];

  wire [XLEN-1:0] va  = (rs == '0) ? '0 : regs[rs];
  wire [XLEN-1:0] vb  = (rt == '0) ? '0 : regs[rt];
  wire [XLEN-1:0] sx  = {{(XLEN-16){imm[15]}}, imm};
  wire [XLEN-1:0] zx  = {{(XLEN-16){1'b0}}, imm};
  wire [XLEN-1:0] pc4 = pc + XLEN'(4);
  wire [XLEN-1:0] btg = pc4 + {sx[XLEN-3:0], 2'b00};
  wire [XLEN-1:0] jtg = {pc4[XLEN-1:28], imem_rdata[25:0], 2'b00};

  logic [XLEN-1:0] res, npc;
  logic [RAW-1:0]  wa;
  logic            we;

  always_comb begin
    res = '0;
    npc = pc4;
    wa  = rt;
    we  = 1'b0;
    case (op)
      OP_REG: begin
        wa = rd;
        we = 1'b1;
        case (fn)
          FN_ADD, FN_ADDU: res = va + vb;
          FN_SUB:          res = va - vb;
          FN_AND:          res = va & vb;
          FN_OR:           res = va | vb;
          FN_NOR:          res = ~(va | vb);
          FN_SLL:          res = vb << sh;
          FN_SRL:          res = vb >> sh;
          default:         we  = 1'b0;
        endcase
      end
      OP_ADDI, OP_ADDIU: begin res = va + sx; we = 1'b1; end
      OP_ANDI: begin res = va & zx; we = 1'b1; end
      OP_XORI: begin res = va ^ zx; we = 1'b1; end
      OP_LUI:  begin res = {imm, 16'h0000}; we = 1'b1; end
      OP_LW:   begin res = dmem_rdata; we = 1'b1; end
      OP_BEQ:  if (va == vb) npc = btg;
      OP_BNE:  if (va != vb) npc = btg;
      OP_J:    npc = jtg;
      OP_JAL:  begin npc = jtg; res = pc4; wa = LINK; we = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      pc <= npc;
      if (we && wa != '0) regs[wa] <= res;
    end
  end

  assign imem_addr  = pc;
  assign dmem_addr  = va + sx;
  assign dmem_wdata = vb;
  assign dmem_we    = (op == OP_SW) && !rst;
  assign dbg_data   = (dbg_sel == '0) ? '0 : regs[dbg_sel];
endmodule

module mini32_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_rdata,
  input logic        dmem_we,
  input logic [4:0]  dbg_sel,
  input logic [31:0] dbg_data
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  wire [5:0]  op   = imem_rdata[31:26];
  wire [31:0] nxt  = imem_addr + 32'd4;
  wire [31:0] boff = {{14{imem_rdata[15]}}, imem_rdata[15:0], 2'b00};
  wire        is_b = (op == 6'b000100) || (op == 6'b000101);
  wire        is_j = (op == 6'b000010) || (op == 6'b000011);

  a_r1_reset_pc: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> imem_addr == 32'd0);

  a_r5_zero_reads_zero: assert property (@(posedge clk) disable iff (rst)
    dbg_sel == 5'd0 |-> dbg_data == 32'd0);

  a_r7_store_strobe: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> op == 6'b101011);

  a_r8_branch_next: assert property (@(posedge clk) disable iff (rst)
    is_b |=> (imem_addr == $past(nxt)) || (imem_addr == $past(nxt) + $past(boff)));

  a_r9_jump_target: assert property (@(posedge clk) disable iff (rst)
    is_j |=> imem_addr == {$past(nxt[31:28]), $past(imem_rdata[25:0]), 2'b00});

  a_r10_sequential: assert property (@(posedge clk) disable iff (rst)
    !is_b && !is_j |=> imem_addr == $past(nxt));

  a_r8_aligned: assert property (@(posedge clk) disable iff (rst)
    imem_addr[1:0] == 2'b00);
endmodule

bind mini32_core mini32_core_chk chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
  .dmem_we(dmem_we), .dbg_sel(dbg_sel), .dbg_data(dbg_data)
);

// File: tb/mini32_core_test.sv
module mini32_core_test;
  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata, dbg_data;
  logic        dmem_we;
  logic [4:0]  dbg_sel = 0;
  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  mini32_core uut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .dbg_sel(dbg_sel), .dbg_data(dbg_data)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] rr(input int fn, rs, rt, rd, sh);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] ii(input int op, rs, rt, imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] jj(input int op, tgt);
    return {6'(op), 26'(tgt)};
  endfunction

  task automatic check(input string req, input logic [31:0] got, exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic reg_is(input string req, input int r, input logic [31:0] exp);
    dbg_sel = 5'(r);
    #1;
    check(req, dbg_data, exp);
  endtask

  task automatic boot(input int n);
    rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_mem;
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'd0;
      dmem[i] <= 32'd0;
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    clear_mem();
    rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 pc", imem_addr, 32'd0);
    for (int r = 0; r < 32; r++) reg_is("R1 reg clear", r, 32'd0);
    rst = 0;
  endtask

  task automatic t_alu;
    clear_mem();
    imem[0]  = ii(8, 0, 1, 16'hFFFF);
    imem[1]  = ii(9, 0, 2, 5);
    imem[2]  = rr(32, 1, 2, 3, 0);
    imem[3]  = rr(33, 2, 2, 4, 0);
    imem[4]  = rr(34, 0, 2, 5, 0);
    imem[5]  = ii(12, 1, 6, 16'h8001);
    imem[6]  = ii(14, 2, 7, 16'hFFFF);
    imem[7]  = ii(15, 0, 8, 16'h8765);
    imem[8]  = rr(36, 1, 2, 9, 0);
    imem[9]  = rr(37, 8, 2, 10, 0);
    imem[10] = rr(39, 2, 0, 11, 0);
    imem[11] = rr(0, 0, 2, 12, 31);
    imem[12] = rr(2, 0, 1, 13, 28);
    imem[13] = rr(2, 0, 8, 14, 0);
    imem[14] = ii(8, 0, 0, 7);
    imem[15] = rr(32, 0, 0, 15, 0);
    boot(16);
    reg_is("R6 addi sext", 1, 32'hFFFFFFFF);
    reg_is("R6 addiu", 2, 32'd5);
    reg_is("R2 add wrap", 3, 32'd4);
    reg_is("R2 addu", 4, 32'd10);
    reg_is("R2 sub", 5, 32'hFFFFFFFB);
    reg_is("R6 andi zext", 6, 32'h00008001);
    reg_is("R6 xori zext", 7, 32'h0000FFFA);
    reg_is("R6 lui", 8, 32'h87650000);
    reg_is("R3 and", 9, 32'd5);
    reg_is("R3 or", 10, 32'h87650005);
    reg_is("R3 nor", 11, 32'hFFFFFFFA);
    reg_is("R4 sll 31", 12, 32'h80000000);
    reg_is("R4 srl zero fill", 13, 32'h0000000F);
    reg_is("R4 srl 0", 14, 32'h87650000);
    reg_is("R5 r0 write ignored", 0, 32'd0);
    reg_is("R5 r0 reads zero", 15, 32'd0);
  endtask

  task automatic t_mem;
    clear_mem();
    imem[0] = ii(8, 0, 1, 16'h0040);
    imem[1] = ii(8, 0, 2, 16'h1234);
    imem[2] = ii(43, 1, 2, 8);
    imem[3] = ii(8, 0, 3, 16'hFFF9);
    imem[4] = ii(43, 1, 3, 16'hFFFC);
    imem[5] = ii(35, 1, 4, 8);
    imem[6] = ii(35, 1, 5, 16'hFFFE);
    boot(7);
    check("R7 sw positive offset", dmem[18], 32'h00001234);
    check("R7 sw negative offset", dmem[15], 32'hFFFFFFF9);
    reg_is("R7 lw", 4, 32'h00001234);
    reg_is("R7 lw low bits ignored", 5, 32'hFFFFFFF9);
  endtask

  task automatic t_branch;
    clear_mem();
    imem[0] = ii(8, 0, 1, 3);
    imem[1] = ii(8, 0, 2, 3);
    imem[2] = ii(4, 1, 2, 2);
    imem[3] = ii(8, 0, 3, 1);
    imem[4] = ii(8, 0, 3, 2);
    imem[5] = ii(5, 1, 2, 1);
    imem[6] = ii(8, 0, 4, 9);
    imem[7] = ii(8, 5, 5, 1);
    imem[8] = ii(5, 5, 1, 16'hFFFE);
    imem[9] = ii(8, 0, 6, 1);
    boot(3);
    check("R8 beq taken target", imem_addr, 32'd20);
    repeat (10) @(posedge clk);
    @(negedge clk);
    reg_is("R8 beq skipped", 3, 32'd0);
    reg_is("R8 bne not taken", 4, 32'd9);
    reg_is("R8 bne backward loop", 5, 32'd3);
    reg_is("R8 loop exit", 6, 32'd1);
  endtask

  task automatic t_jump;
    clear_mem();
    imem[0] = jj(3, 4);
    imem[1] = ii(8, 0, 1, 1);
    imem[4] = ii(8, 0, 2, 2);
    imem[5] = jj(2, 8);
    imem[6] = ii(8, 0, 3, 3);
    imem[8] = ii(8, 0, 4, 4);
    boot(1);
    check("R9 jal target", imem_addr, 32'd16);
    reg_is("R9 jal link", 31, 32'd4);
    repeat (3) @(posedge clk);
    @(negedge clk);
    reg_is("R9 jal skipped slot", 1, 32'd0);
    reg_is("R9 j skipped slot", 3, 32'd0);
    reg_is("R9 j target reached", 4, 32'd4);
    reg_is("R11 debug read", 2, 32'd2);
  endtask

  task automatic t_undef;
    clear_mem();
    imem[0] = ii(8, 0, 1, 5);
    imem[1] = ii(63, 0, 1, 16'h0040);
    imem[2] = rr(8, 0, 0, 1, 0);
    imem[3] = rr(42, 0, 0, 1, 0);
    imem[4] = ii(47, 0, 1, 0);
    boot(5);
    check("R10 pc advanced by 4", imem_addr, 32'd20);
    reg_is("R10 no register change", 1, 32'd5);
    check("R10 no memory change", dmem[0], 32'd0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_alu();
        t_mem();
        t_branch();
        t_jump();
        t_undef();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule